// File: doc/BRIEF.md
# Periodic Loaded Battery Test Scheduler

This block decides when a backup cell is put under a test load and keeps a latched, active-low warning once the cell has read weak under that load. Time is measured only in ticks of a scaled timebase input, so every interval is a parameter counted in ticks. A run of ticks can stand for a day in silicon, or for a few cycles on a bench. The analog load and the comparator are outside the block. It drives a load-enable strobe and samples the comparator result while that strobe is high.

Testing only runs while the supply is good and the supply-recovery delay has finished. A power-up test happens at the first tick after that. Tests then repeat on a long period while the cell is good, and on a short period while the warning is raised. The warning clears only after the cell has been detached long enough, then reattached, and has then passed a test. When no warning is raised, the presence flag is not watched at all.

Top module: `bat_test_sched`

## Requirements
- R1: Until both `supply_ok` and `recov_done` are high, no test starts. Once both are high, a test starts at the first `tick` after that, whatever the warning state. `load_en` rises on the clock edge where that tick is sampled.
- R2: If `supply_ok` or `recov_done` is low at a clock edge, `load_en` is low after that edge. All interval counting restarts when both inputs come back high.
- R3: `load_en` stays high for exactly `PULSE_TICKS` ticks. If `batt_low` is high in any cycle while `load_en` is high, `warn_n` goes to 0 on the same edge where `load_en` falls.
- R4: With no warning raised (`warn_n` = 1), the next test starts on the `NORM_TICKS`-th tick after the previous pulse ended.
- R5: While `warn_n` = 0, the next test starts on the `WARN_TICKS`-th tick after the previous pulse ended.
- R6: Once `warn_n` is 0, it stays 0 through passing tests and through loss and return of the supply, unless R8 applies.
- R7: While warning, if `batt_present` goes low and then high again before `DETACH_TICKS` ticks have been seen while it was low, the warning does not clear.
- R8: While warning, if `batt_present` goes high again after being low for at least `DETACH_TICKS` ticks, a test starts at the next tick. If that test passes, `warn_n` returns to 1 at its end, and the long period of R4 then counts from zero.
- R9: While `warn_n` = 1, changes on `batt_present` have no effect on `load_en`, `warn_n` or the test schedule.
- R10: After reset, `load_en` = 0 and `warn_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Main supply within tolerance |
| recov_done | input | 1 | Supply-recovery delay has expired |
| batt_low | input | 1 | Comparator: cell below threshold under load |
| batt_present | input | 1 | Cell attached |
| tick | input | 1 | One-cycle timebase pulse |
| load_en | output | 1 | Connects the test load (registered) |
| warn_n | output | 1 | Active-low weak-cell warning (registered) |

## Verification
The bench goes after a short weak reading in the middle of a pulse. A design that samples only at the end of the pulse would miss it and leave the warning high. It removes a flagged cell for fewer ticks than the minimum and checks that the warning stays low. A design that treats any reattach as a replacement would clear the warning too early. It also checks that a valid reattach starts a test ahead of the warning-mode schedule, and that the long period is timed from the clear. A design that kept the old count would start that test at the wrong tick. Finally it drops the supply during a pulse and while a warning is raised, and checks that the load cuts off at once, the warning survives, and a fresh power-up test happens even though the warning is still active.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_TEST
  } bts_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/bts_interval.sv
module bts_interval #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // limit is always at least 1, so limit-1 does not wrap
  assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/bts_detach_watch.sv
module bts_detach_watch #(
  parameter int DETACH_TICKS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic warn,
  input  logic tick,
  input  logic batt_present,
  input  logic take,
  output logic armed
);
  localparam int DW = $clog2(DETACH_TICKS + 1);
  localparam logic [DW-1:0] DMIN = DW'(DETACH_TICKS);

  logic [DW-1:0] gone_cnt;
  logic          prs_q;
  logic          valid_return;

  assign valid_return = warn && batt_present && !prs_q && (gone_cnt >= DMIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      gone_cnt <= '0;
      prs_q    <= 1'b1;
      armed    <= 1'b0;
    end else if (!active) begin
      gone_cnt <= '0;
      prs_q    <= batt_present;
      armed    <= 1'b0;
    end else begin
      prs_q <= batt_present;
      if (batt_present)
        gone_cnt <= '0;
      else if (warn && tick && gone_cnt != DMIN)
        gone_cnt <= gone_cnt + 1'b1;
      armed <= (armed && !take) || valid_return;
    end
  end
endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
#(
  parameter int NORM_TICKS  = 86400,
  parameter int WARN_TICKS  = 5,
  parameter int PULSE_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  input  logic batt_low,
  input  logic armed,
  output logic take,
  output logic load_en,
  output logic warn_n
);
  localparam int CW = $clog2(max3(NORM_TICKS, WARN_TICKS, PULSE_TICKS) + 1);

  bts_state_e    state;
  logic          fail_seen;
  logic          repl_test;
  logic [CW-1:0] limit;
  logic          iv_last;
  logic          iv_clr;
  logic          start;
  logic          finish;

  always_comb begin
    if (state == ST_TEST)  limit = CW'(PULSE_TICKS);
    else if (!warn_n)      limit = CW'(WARN_TICKS);
    else                   limit = CW'(NORM_TICKS);
  end

  assign start  = active && tick &&
                  ((state == ST_IDLE) || (state == ST_WAIT && (armed || iv_last)));
  assign finish = active && tick && (state == ST_TEST) && iv_last;
  assign iv_clr = !active || start || finish || (state == ST_IDLE);
  assign take   = start && armed;

  bts_interval #(.CW(CW)) u_iv (
    .clk   (clk),
    .rst   (rst),
    .clr   (iv_clr),
    .tick  (tick),
    .limit (limit),
    .last  (iv_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      load_en   <= 1'b0;
      warn_n    <= 1'b1;
      fail_seen <= 1'b0;
      repl_test <= 1'b0;
    end else if (!active) begin
      state     <= ST_IDLE;
      load_en   <= 1'b0;
      fail_seen <= 1'b0;
      repl_test <= 1'b0;
    end else if (start) begin
      state     <= ST_TEST;
      load_en   <= 1'b1;
      fail_seen <= 1'b0;
      repl_test <= armed;
    end else if (state == ST_TEST) begin
      if (batt_low) fail_seen <= 1'b1;
      if (finish) begin
        state     <= ST_WAIT;
        load_en   <= 1'b0;
        repl_test <= 1'b0;
        if (fail_seen || batt_low) warn_n <= 1'b0;
        else if (repl_test)        warn_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bat_test_sched.sv
module bat_test_sched #(
  parameter int NORM_TICKS   = 86400,
  parameter int WARN_TICKS   = 5,
  parameter int PULSE_TICKS  = 1,
  parameter int DETACH_TICKS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic recov_done,
  input  logic batt_low,
  input  logic batt_present,
  input  logic tick,
  output logic load_en,
  output logic warn_n
);
  logic active;
  logic armed;
  logic take;

  assign active = supply_ok && recov_done;

  bts_detach_watch #(.DETACH_TICKS(DETACH_TICKS)) u_det (
    .clk          (clk),
    .rst          (rst),
    .active       (active),
    .warn         (!warn_n),
    .tick         (tick),
    .batt_present (batt_present),
    .take         (take),
    .armed        (armed)
  );

  bts_seq #(
    .NORM_TICKS  (NORM_TICKS),
    .WARN_TICKS  (WARN_TICKS),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .tick     (tick),
    .batt_low (batt_low),
    .armed    (armed),
    .take     (take),
    .load_en  (load_en),
    .warn_n   (warn_n)
  );
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int PULSE_TICKS = 1
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic recov_done,
  input logic tick,
  input logic load_en,
  input logic warn_n
);
  localparam int PW = $clog2(PULSE_TICKS + 1) + 1;
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || !load_en) pcnt <= '0;
    else if (tick)       pcnt <= pcnt + 1'b1;
  end

  p_down_no_load_r2: assert property (@(posedge clk) disable iff (rst)
    !(supply_ok && recov_done) |=> !load_en);

  p_start_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(load_en) |-> $past(tick));

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (pcnt < PW'(PULSE_TICKS)));

  p_warn_at_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_n) |-> $fell(load_en));

  p_clear_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_n) |-> $fell(load_en));

  p_warn_hold_down_r6: assert property (@(posedge clk) disable iff (rst)
    !(supply_ok && recov_done) |=> $stable(warn_n));
endmodule

bind bat_test_sched bts_checker #(.PULSE_TICKS(PULSE_TICKS)) u_bts_chk (
  .clk        (clk),
  .rst        (rst),
  .supply_ok  (supply_ok),
  .recov_done (recov_done),
  .tick       (tick),
  .load_en    (load_en),
  .warn_n     (warn_n)
);

// File: tb/test_bat_test_sched.sv
module test_bat_test_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NORM  = 12;
  localparam int WARN  = 5;
  localparam int PULSE = 2;
  localparam int DET   = 3;

  typedef struct {
    int    stamp;
    bit    load;
    bit    wn;
    string req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic supply_ok = 0, recov_done = 0, batt_low = 0, batt_present = 1, tick = 0;
  logic load_en, warn_n;

  int nchk = 0, nfail = 0, tcount = 0, ph = 0;
  exp_t exp_q[$];
  logic [1:0] prev = 2'b01;

  bat_test_sched #(
    .NORM_TICKS(NORM), .WARN_TICKS(WARN), .PULSE_TICKS(PULSE), .DETACH_TICKS(DET)
  ) i_bat_test_sched (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .recov_done(recov_done),
    .batt_low(batt_low), .batt_present(batt_present), .tick(tick),
    .load_en(load_en), .warn_n(warn_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    tick = (ph == 0);
  end

  always @(posedge clk) if (tick) tcount <= tcount + 1;

  // monitor: each output change is compared with the head of the queue
  always @(negedge clk) begin
    if (!rst && {load_en, warn_n} != prev) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL unexpected change at tick %0d: load=%0b warn_n=%0b expected no change",
                 tcount, load_en, warn_n);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.stamp != tcount || e.load != load_en || e.wn != warn_n) begin
          nfail++;
          $display("FAIL %s: got tick=%0d load=%0b warn_n=%0b expected tick=%0d load=%0b warn_n=%0b",
                   e.req, tcount, load_en, warn_n, e.stamp, e.load, e.wn);
        end
      end
      prev = {load_en, warn_n};
    end
  end

  task automatic push(input int s, input bit l, input bit w, input string r);
    exp_t e;
    e.stamp = s; e.load = l; e.wn = w; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic chk(input bit l, input bit w, input string r);
    nchk++;
    if (load_en !== l || warn_n !== w) begin
      nfail++;
      $display("FAIL %s: got load=%0b warn_n=%0b expected load=%0b warn_n=%0b",
               r, load_en, warn_n, l, w);
    end
  endtask

  task automatic chk_drained(input string r);
    nchk++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL %s: %0d expected changes missing, expected 0", r, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int b, c, d;
    repeat (6) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(1'b0, 1'b1, "R10 reset state");

    // R1: supply good but recovery pending -> nothing
    supply_ok = 1;
    wait_ticks(5);
    chk(1'b0, 1'b1, "R1 no test before recovery");

    recov_done = 1;
    b = tcount;
    push(b+1,  1, 1, "R1 first test on first tick");
    push(b+3,  0, 1, "R3 pulse length, good cell");
    push(b+15, 1, 1, "R4 normal period");
    push(b+17, 0, 0, "R3 mid-pulse low reading sets warning");
    push(b+22, 1, 0, "R5 warning period");
    push(b+24, 0, 0, "R6 passing test keeps warning");
    push(b+29, 1, 0, "R5 warning period repeats");
    push(b+31, 0, 0, "R7 short detach keeps warning");
    push(b+35, 1, 0, "R8 valid reattach starts test at next tick");
    push(b+37, 0, 1, "R8 warning clears after passing test");
    push(b+49, 1, 1, "R8 normal period restarts from clear");

    wait_ticks(16);                  // now at tick b+16, inside second test
    batt_low = 1;
    @(negedge clk);
    batt_low = 0;
    wait_ticks(8);                   // b+24
    batt_present = 0;
    wait_ticks(2);                   // b+26
    batt_present = 1;
    wait_ticks(5);                   // b+31
    batt_present = 0;
    wait_ticks(3);                   // b+34
    batt_present = 1;
    wait_ticks(5);                   // b+39
    batt_present = 0;                // R9: ignored without warning
    wait_ticks(5);                   // b+44
    batt_present = 1;
    chk(1'b0, 1'b1, "R9 removal without warning has no effect");
    wait_ticks(5);                   // b+49, load just rose

    push(b+49, 0, 1, "R2 supply loss cuts load");
    supply_ok = 0;
    wait_ticks(20);
    chk(1'b0, 1'b1, "R2 no test while supply down");
    chk_drained("R4");

    supply_ok = 1;
    c = tcount;
    push(c+1, 1, 1, "R1 power-up test");
    push(c+3, 0, 0, "R3 weak cell flagged at power-up");
    wait_ticks(1);
    batt_low = 1;
    wait_ticks(2);                   // c+3
    batt_low = 0;
    wait_ticks(1);                   // c+4
    supply_ok = 0;
    wait_ticks(10);
    chk(1'b0, 1'b0, "R6 warning held through power loss");

    supply_ok = 1;
    d = tcount;
    push(d+1,  1, 0, "R1 retest after power-up with warning");
    push(d+3,  0, 0, "R6 warning kept without replacement");
    push(d+8,  1, 0, "R5 warning period after power-up");
    push(d+10, 0, 0, "R6 warning kept");
    wait_ticks(12);
    chk_drained("R5");
    chk(1'b0, 1'b0, "R6 final state");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule